// File: doc/BRIEF.md
# Bit-Serial Shift-and-Add Multiplier

This block multiplies two unsigned N-bit operands one bit at a time. A pulse on `start` while the block is idle captures both operands and begins a nested-loop schedule. The outer loop steps once per multiplier bit. For each outer step, the inner loop runs N cycles, and in each of these cycles a one-bit serial adder folds the current multiplicand bit, gated by the current multiplier bit, into the upper half of the running product. A single pass cycle then closes each outer step. It shifts the final adder carry into the upper half, moves the lowest upper-half bit into the lower half of the product, advances the multiplier and clears the adder carry.

The schedule is driven by two small binary counters, an inner one (j) and an outer one (i). Each counter advances only when its count enable is high and raises a terminal-count flag at its top value N-1. The controller has four states. IDLE waits for `start`. INNER runs the serial add and leaves to PASS on j terminal count. PASS does the end-of-row work and goes back to INNER, or to DONE on i terminal count. DONE asserts `done` for one cycle and returns to IDLE. A product takes N*(N+1) busy cycles plus the DONE cycle.

Top module: `bitser_mul`

## Requirements
- R1: While `rst_n` is low and after its release, `done` is 0 and `product` is all zeros until a multiplication completes.
- R2: When `done` is high, `product` equals the unsigned product of the `op_a` and `op_b` values captured at the accepted `start`. The lower N bits hold the low half and the upper N bits hold the high half.
- R3: If `start` is sampled high in IDLE at rising edge k, `done` is high exactly in the cycle after edge k+N*(N+1), and it is low in the cycle before and the cycle after.
- R4: A `start` pulse that arrives while a multiplication is in progress is ignored. The result and the timing of `done` are unchanged.
- R5: `op_a` and `op_b` are sampled only at an accepted `start`. Changing them during a run does not affect the result.
- R6: After `done`, `product` holds its value until the next accepted `start`.
- R7: Boundary operands (zero, one, all-ones) give exact products, including the largest product (2^N-1)^2.
- R8: A `start` that is held high during the DONE cycle is ignored. No new run begins and `done` does not rise again.
- R9: In every INNER cycle, shift-A, select-sum and shift-HI are asserted together, and shift-B, shift-LO and pass-reset are low.
- R10: In every PASS cycle, shift-B, shift-HI, shift-LO and pass-reset are asserted together, and shift-A and select-sum are low.
- R11: The INNER cycle in which j reaches terminal count is followed by a PASS cycle. A PASS cycle in which i reaches terminal count is followed by `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication (accepted only in IDLE) |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2N | {HI, LO} product register |

## Verification
The bench builds the block with N=4. At that size all 256 operand pairs can be run exhaustively, which covers every carry pattern of the serial adder and every terminal-count crossing of both counters, in a few thousand cycles. Directed runs then inject a `start` during a busy run and change the operands mid-run. Other runs hold `start` through the DONE cycle, and `done` is timed at exactly 4*5 cycles after acceptance.

// File: rtl/bitser_mul_pkg.sv
package bitser_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INNER = 2'd1,
        ST_PASS  = 2'd2,
        ST_DONE  = 2'd3
    } mul_state_e;

endpackage

// File: rtl/bitser_mul_count.sv
// Loop counter: advances on ce, wraps after MAXV, flags MAXV.
module bitser_mul_count #(
    parameter int W    = 3,
    parameter int MAXV = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ce,
    output logic tc
);
    logic [W-1:0] cnt_q;
    localparam logic [W-1:0] TOP = W'(MAXV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (ce) begin
            if (cnt_q == TOP) cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tc = (cnt_q == TOP);
endmodule

// File: rtl/bitser_mul_ctrl.sv
// Controller: four states sequenced by inner (j) and outer (i) counters.
module bitser_mul_ctrl
    import bitser_mul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic sh_a,
    output logic sel_sum,
    output logic sh_hi,
    output logic sh_b,
    output logic sh_lo,
    output logic clr_pass,
    output logic done,
    output logic j_tc,
    output logic i_tc
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    mul_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_INNER;
            ST_INNER: if (j_tc)  st_d = ST_PASS;
            ST_PASS:  st_d = i_tc ? ST_DONE : ST_INNER;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // output strobes
    always_comb begin
        load     = 1'b0;
        sh_a     = 1'b0;
        sel_sum  = 1'b0;
        sh_hi    = 1'b0;
        sh_b     = 1'b0;
        sh_lo    = 1'b0;
        clr_pass = 1'b0;
        done     = 1'b0;
        unique case (st_q)
            ST_IDLE:  load = start;
            ST_INNER: begin
                sh_a    = 1'b1;
                sel_sum = 1'b1;
                sh_hi   = 1'b1;
            end
            ST_PASS:  begin
                sh_b     = 1'b1;
                sh_hi    = 1'b1;
                sh_lo    = 1'b1;
                clr_pass = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    bitser_mul_count #(.W(CW), .MAXV(N-1)) u_cnt_j (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (load | clr_pass),
        .ce   (sh_a),
        .tc   (j_tc)
    );

    bitser_mul_count #(.W(CW), .MAXV(N-1)) u_cnt_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (load),
        .ce   (sh_b),
        .tc   (i_tc)
    );
endmodule

// File: rtl/bitser_mul_dp.sv
// Datapath: rotating operand registers, serial adder, HI/LO product halves.
module bitser_mul_dp #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    input  logic           sh_a,
    input  logic           sel_sum,
    input  logic           sh_hi,
    input  logic           sh_b,
    input  logic           sh_lo,
    input  logic           clr_pass,
    output logic [2*N-1:0] product
);
    logic [N-1:0] a_q, b_q, hi_q, lo_q;
    logic         cy_q;
    logic         pp, sum, cout, hi_in;

    // one-bit serial adder
    assign pp    = a_q[0] & b_q[0];
    assign sum   = hi_q[0] ^ pp ^ cy_q;
    assign cout  = (hi_q[0] & pp) | (hi_q[0] & cy_q) | (pp & cy_q);
    assign hi_in = sel_sum ? sum : cy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            hi_q <= '0;
            lo_q <= '0;
            cy_q <= 1'b0;
        end else if (load) begin
            a_q  <= op_a;
            b_q  <= op_b;
            hi_q <= '0;
            lo_q <= '0;
            cy_q <= 1'b0;
        end else begin
            if (sh_a)  a_q  <= {a_q[0], a_q[N-1:1]};
            if (sh_b)  b_q  <= {b_q[0], b_q[N-1:1]};
            if (sh_hi) hi_q <= {hi_in, hi_q[N-1:1]};
            if (sh_lo) lo_q <= {hi_q[0], lo_q[N-1:1]};
            if (clr_pass)     cy_q <= 1'b0;
            else if (sel_sum) cy_q <= cout;
        end
    end

    assign product = {hi_q, lo_q};
endmodule

// File: rtl/bitser_mul.sv
module bitser_mul #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic           done,
    output logic [2*N-1:0] product
);
    logic load, sh_a, sel_sum, sh_hi, sh_b, sh_lo, clr_pass, j_tc, i_tc;

    bitser_mul_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .sh_a    (sh_a),
        .sel_sum (sel_sum),
        .sh_hi   (sh_hi),
        .sh_b    (sh_b),
        .sh_lo   (sh_lo),
        .clr_pass(clr_pass),
        .done    (done),
        .j_tc    (j_tc),
        .i_tc    (i_tc)
    );

    bitser_mul_dp #(.N(N)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .op_a    (op_a),
        .op_b    (op_b),
        .sh_a    (sh_a),
        .sel_sum (sel_sum),
        .sh_hi   (sh_hi),
        .sh_b    (sh_b),
        .sh_lo   (sh_lo),
        .clr_pass(clr_pass),
        .product (product)
    );
endmodule

// File: rtl/bitser_mul_chk.sv
module bitser_mul_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic sh_a,
    input logic sel_sum,
    input logic sh_hi,
    input logic sh_b,
    input logic sh_lo,
    input logic clr_pass,
    input logic j_tc,
    input logic i_tc
);
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_inner_group: assert property (@(posedge clk) disable iff (!rst_n)
        sh_a |-> (sel_sum && sh_hi && !sh_b && !sh_lo && !clr_pass));

    a_r10_pass_group: assert property (@(posedge clk) disable iff (!rst_n)
        sh_b |-> (sh_hi && sh_lo && clr_pass && !sh_a && !sel_sum));

    a_r11_inner_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_a && j_tc) |=> sh_b);

    a_r11_outer_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_b && i_tc) |=> done);

    a_r9_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sh_a, sh_b, done}));
endmodule

bind bitser_mul bitser_mul_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .sh_a    (sh_a),
    .sel_sum (sel_sum),
    .sh_hi   (sh_hi),
    .sh_b    (sh_b),
    .sh_lo   (sh_lo),
    .clr_pass(clr_pass),
    .j_tc    (j_tc),
    .i_tc    (i_tc)
);

// File: tb/bitser_mul_tb_top.sv
`timescale 1ns/1ps
module bitser_mul_tb_top;
    localparam int N   = 4;
    localparam int LAT = N * (N + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   op_a = '0;
    logic [N-1:0]   op_b = '0;
    logic           done;
    logic [2*N-1:0] product;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    bitser_mul #(.N(N)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_a   (op_a),
        .op_b   (op_b),
        .done   (done),
        .product(product)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] mul_ref(input logic [N-1:0] x, input logic [N-1:0] y);
        logic [2*N-1:0] acc = '0;
        for (int k = 0; k < N; k++)
            if (y[k]) acc = acc + ({{N{1'b0}}, x} << k);
        return acc;
    endfunction

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
        check(product == '0, "R1 product in reset", 64'(product), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
        check(product == '0, "R1 product after reset", 64'(product), 64'd0);
    endtask

    // R2/R3/R4/R5/R6/R8: one full multiplication with optional disturbances
    task automatic t_mul(input logic [N-1:0] av, input logic [N-1:0] bv,
                         input bit inject, input bit hold_at_done, input string tag);
        logic [2*N-1:0] exp;
        exp = mul_ref(av, bv);
        @(negedge clk);
        op_a  = av;
        op_b  = bv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            op_a = ~av;   // R5: operands change during the run
            op_b = av ^ bv;
        end
        for (int c = 1; c < LAT; c++) begin
            start = (inject && (c == 3 || c == LAT - 3)) ? 1'b1 : 1'b0; // R4
            @(negedge clk);
        end
        start = 1'b0;
        check(done == 1'b0, {tag, " R3 done early"}, 64'(done), 64'd0);
        @(negedge clk);
        check(done == 1'b1, {tag, " R3 done on time"}, 64'(done), 64'd1);
        check(product == exp, {tag, " R2 product"}, 64'(product), 64'(exp));
        if (hold_at_done) start = 1'b1;   // R8
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, {tag, " R3 done one cycle"}, 64'(done), 64'd0);
        if (hold_at_done) begin
            bit rose = 1'b0;
            for (int c = 0; c < LAT + 3; c++) begin
                @(negedge clk);
                if (done) rose = 1'b1;
            end
            check(!rose, {tag, " R8 start at done ignored"}, 64'(rose), 64'd0);
        end else begin
            repeat (3) @(negedge clk);
        end
        check(product == exp, {tag, " R6 product held"}, 64'(product), 64'(exp));
    endtask

    task automatic t_exhaustive();
        for (int x = 0; x < (1 << N); x++)
            for (int y = 0; y < (1 << N); y++)
                t_mul(N'(x), N'(y), 1'b0, 1'b0, "R2 exhaustive");
    endtask

    task automatic t_boundary();
        t_mul('0, '1, 1'b0, 1'b0, "R7 zero");
        t_mul(N'(1), '1, 1'b0, 1'b0, "R7 one");
        t_mul('1, '1, 1'b0, 1'b0, "R7 max");
    endtask

    task automatic t_busy();
        t_mul(N'(11), N'(13), 1'b1, 1'b0, "R4 R5 busy start");
        t_mul('1, N'(9), 1'b1, 1'b0, "R4 R5 busy start 2");
    endtask

    task automatic t_start_at_done();
        t_mul(N'(7), N'(6), 1'b0, 1'b1, "R8 hold start");
    endtask

    initial begin
        t_reset();
        t_boundary();
        t_busy();
        t_start_at_done();
        t_exhaustive();   // R9 R10 R11 exercised through every product
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule